// File: doc/BRIEF.md
# Peer Snoop Responder with Forwarding State

This block is the snoop side of one caching node in a broadcast coherence scheme over point-to-point links. It keeps a small table of per-line coherence states (Invalid, Shared, Exclusive, Modified and a Forwarding state that marks the one sharer that supplies clean data). Peers broadcast snoops that carry a line index, a requester tag and a kind: shared read, read-for-ownership or invalidate. For every snoop the block returns exactly one answer, moves the local line to its new state and, when it hands out data, names the state the requester must install.

Two conditions hold a line against further snoops. The first is a data handover, which lasts until the new owner returns its data acknowledge. The second is a local eviction of a dirty line, which lasts until home confirms the writeback. Held snoops wait in a small ordered queue and are replayed one per cycle once their line is released. A local port lets the node's own request logic mark a line as having a request in flight, in which case snoops to that line get a conflict answer. The same port installs the final state when that request completes.

Top module: `snoop_responder`

## Requirements
- R1: Each accepted snoop produces exactly one response, registered: a snoop accepted while the hold queue is empty and its line is free is answered in the cycle after it is presented, and no response appears without a snoop being issued. Response kinds: 0 invalid ack, 1 shared ack, 2 data, 3 conflict. Snoop kinds: 0 shared read, 1 read-for-ownership, 2 and 3 invalidate. State codes: 0 I, 1 S, 2 E, 3 M, 4 F.
- R2: A shared read that finds F or E answers with data and install state F; the local line becomes S.
- R3: A shared read that finds M answers with data and install state M; the local line becomes I.
- R4: A read-for-ownership that finds M or E answers with data and install state equal to the local state (M or E); the local line becomes I.
- R5: A read-for-ownership that finds S answers invalid ack with no data; one that finds F answers invalid ack with data attached. Both leave the line I.
- R6: A shared read that finds S answers shared ack with no data. Any snoop to an I line answers invalid ack with no data. An invalidate answers invalid ack with no data and leaves the line I. The install field reads 0 for every response that is not of kind data.
- R7: After any response that carries data, snoops to that line are held and not answered until a data acknowledge for that line arrives.
- R8: While the local request flag for a line is set, a snoop to it (line not held) answers conflict with no data and leaves the state unchanged; a local completion clears the flag and installs the given state.
- R9: Evicting an M line raises the writeback strobe with the line index in the next cycle, makes the line I and holds snoops to it until the writeback acknowledge, after which they answer invalid ack. Evicting a line in any other state makes it I with no writeback.
- R10: Held snoops are replayed in arrival order, one per cycle, from the oldest; while any snoop is held, every newer snoop queues behind it, even one to a free line.
- R11: The hold queue has SLOTS entries; request-ready is low exactly while it is full.
- R12: After reset every line is I, no line is held or pending, request-ready is high and no response or writeback is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Incoming snoop present |
| reqReady | output | 1 | Snoop can be taken (queue not full) |
| reqType | input | 2 | Snoop kind |
| reqLine | input | log2(LINES) | Line index of the snoop |
| reqId | input | ID_W | Requester tag |
| rspValid | output | 1 | Response present this cycle |
| rspKind | output | 2 | Response kind |
| rspHasData | output | 1 | Line data attached |
| rspInstall | output | 3 | State the requester installs |
| rspId | output | ID_W | Requester tag echoed |
| rspLine | output | log2(LINES) | Line index echoed |
| ownReqValid | input | 1 | Local request to a line starts |
| ownReqLine | input | log2(LINES) | Line of the local request |
| ownDoneValid | input | 1 | Local request completes |
| ownDoneLine | input | log2(LINES) | Line of the completed request |
| ownDoneState | input | 3 | State installed on completion |
| evictValid | input | 1 | Local eviction of a line |
| evictLine | input | log2(LINES) | Line being evicted |
| wbValid | output | 1 | Writeback to home issued |
| wbLine | output | log2(LINES) | Line being written back |
| wbAckValid | input | 1 | Home confirms a writeback |
| wbAckLine | input | log2(LINES) | Line whose writeback is confirmed |
| dackValid | input | 1 | New owner acknowledges received data |
| dackLine | input | log2(LINES) | Line being acknowledged |

## Verification
On every cycle the assertions check that each response follows exactly one issued snoop, that a data response always carries data and a conflict never does, that a data handover leaves a hold in place, that an eviction leaves its line Invalid, and that the queue is never pushed when full nor popped when empty. The state-transition table for each snoop kind, the release of held snoops by the right acknowledge, the replay order behind a blocked head and the backpressure when the queue fills only show up in the bench's scenarios. There a behavioural model predicts every output on every clock.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_M = 3'd3,
    ST_F = 3'd4
  } lineState_t;

  typedef enum logic [1:0] {
    SNP_SHR = 2'd0,
    SNP_RFO = 2'd1,
    SNP_INV = 2'd2,
    SNP_INV2 = 2'd3
  } snpType_t;

  typedef enum logic [1:0] {
    RSP_IACK = 2'd0,
    RSP_SACK = 2'd1,
    RSP_DATA = 2'd2,
    RSP_CNFL = 2'd3
  } rspKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       useHead;  // candidate snoop is the queue head
    logic       push;     // store incoming snoop in hold queue
    logic       pop;      // retire queue head
    logic       wrState;  // update candidate line state
    lineState_t wrVal;
    logic       setDack;  // data handed out: hold line until data ack
  } ctlStrobe_t;

endpackage

// File: rtl/snoop_dpath.sv
module snoop_dpath
  import snoop_pkg::*;
#(
  parameter int LINES = 8,
  parameter int ID_W  = 3,
  parameter int SLOTS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       str,
  input  logic [IDX_W-1:0] reqLine,
  input  logic [ID_W-1:0]  reqId,
  input  logic [1:0]       reqType,
  input  logic             ownReqValid,
  input  logic [IDX_W-1:0] ownReqLine,
  input  logic             ownDoneValid,
  input  logic [IDX_W-1:0] ownDoneLine,
  input  logic [2:0]       ownDoneState,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictLine,
  input  logic             wbAckValid,
  input  logic [IDX_W-1:0] wbAckLine,
  input  logic             dackValid,
  input  logic [IDX_W-1:0] dackLine,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic [IDX_W-1:0] headLine,
  output logic [ID_W-1:0]  headId,
  output logic [1:0]       headType,
  output lineState_t       headState,
  output logic             headPend,
  output logic             headBlk,
  output lineState_t       inState,
  output logic             inPend,
  output logic             inBlk,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbLine
);

  lineState_t       stTab [LINES];
  logic [LINES-1:0] pendVec, dackBlk, wbBlk;

  logic [IDX_W-1:0] qLine [SLOTS];
  logic [ID_W-1:0]  qId   [SLOTS];
  logic [1:0]       qType [SLOTS];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] cnt;

  logic [IDX_W-1:0] candLine;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fifoEmpty = (cnt == '0);
  assign fifoFull  = (cnt == CNT_W'(SLOTS));
  assign headLine  = qLine[rdPtr];
  assign headId    = qId[rdPtr];
  assign headType  = qType[rdPtr];
  assign headState = stTab[headLine];
  assign headPend  = pendVec[headLine];
  assign headBlk   = dackBlk[headLine] | wbBlk[headLine];
  assign inState   = stTab[reqLine];
  assign inPend    = pendVec[reqLine];
  assign inBlk     = dackBlk[reqLine] | wbBlk[reqLine];
  assign candLine  = str.useHead ? headLine : reqLine;

  // hold queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else begin
      if (str.push) begin
        qLine[wrPtr] <= reqLine;
        qId[wrPtr]   <= reqId;
        qType[wrPtr] <= reqType;
        wrPtr        <= nextPtr(wrPtr);
      end
      if (str.pop) rdPtr <= nextPtr(rdPtr);
      cnt <= cnt + CNT_W'(str.push) - CNT_W'(str.pop);
    end
  end

  // line state table and hold flags; local events win over snoop updates
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) stTab[i] <= ST_I;
      pendVec <= '0;
      dackBlk <= '0;
      wbBlk   <= '0;
      wbValid <= 1'b0;
      wbLine  <= '0;
    end else begin
      wbValid <= 1'b0;
      if (str.wrState) stTab[candLine] <= str.wrVal;
      if (dackValid) dackBlk[dackLine] <= 1'b0;
      if (str.setDack) dackBlk[candLine] <= 1'b1;
      if (ownReqValid) pendVec[ownReqLine] <= 1'b1;
      if (ownDoneValid) begin
        pendVec[ownDoneLine] <= 1'b0;
        stTab[ownDoneLine]   <= lineState_t'(ownDoneState);
      end
      if (wbAckValid) wbBlk[wbAckLine] <= 1'b0;
      if (evictValid) begin
        stTab[evictLine] <= ST_I;
        if (stTab[evictLine] == ST_M) begin
          wbBlk[evictLine] <= 1'b1;
          wbValid          <= 1'b1;
          wbLine           <= evictLine;
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    str.push |-> !fifoFull); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    str.pop |-> !fifoEmpty); // R10
  AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    str.setDack |=> (dackBlk != '0)); // R7
  AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |=> (stTab[$past(evictLine)] == ST_I)); // R9

endmodule

// File: rtl/snoop_ctrl.sv
module snoop_ctrl
  import snoop_pkg::*;
#(
  parameter int LINES = 8,
  parameter int ID_W  = 3,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] reqLine,
  input  logic [ID_W-1:0]  reqId,
  input  logic [1:0]       reqType,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic [IDX_W-1:0] headLine,
  input  logic [ID_W-1:0]  headId,
  input  logic [1:0]       headType,
  input  lineState_t       headState,
  input  logic             headPend,
  input  logic             headBlk,
  input  lineState_t       inState,
  input  logic             inPend,
  input  logic             inBlk,
  output ctlStrobe_t       str,
  output logic             reqReady,
  output logic             rspValid,
  output rspKind_t         rspKind,
  output logic             rspHasData,
  output lineState_t       rspInstall,
  output logic [ID_W-1:0]  rspId,
  output logic [IDX_W-1:0] rspLine
);

  logic             useHead, useIn, fire;
  lineState_t       cSt;
  logic             cPend;
  snpType_t         cType;
  logic [ID_W-1:0]  cId;
  logic [IDX_W-1:0] cLine;
  rspKind_t         nKind;
  logic             nData;
  lineState_t       nInst, nSt;

  assign useHead  = !fifoEmpty && !headBlk;
  assign useIn    = reqValid && fifoEmpty && !inBlk;
  assign fire     = useHead || useIn;
  assign reqReady = !fifoFull;

  assign cSt   = useHead ? headState : inState;
  assign cPend = useHead ? headPend : inPend;
  assign cType = snpType_t'(useHead ? headType : reqType);
  assign cId   = useHead ? headId : reqId;
  assign cLine = useHead ? headLine : reqLine;

  // response and next-state decision for the candidate snoop
  always_comb begin
    nKind = RSP_IACK;
    nData = 1'b0;
    nInst = ST_I;
    nSt   = cSt;
    if (cPend) begin
      nKind = RSP_CNFL;
    end else begin
      unique case (cType)
        SNP_SHR: begin
          unique case (cSt)
            ST_S: nKind = RSP_SACK;
            ST_F, ST_E: begin
              nKind = RSP_DATA; nData = 1'b1; nInst = ST_F; nSt = ST_S;
            end
            ST_M: begin
              nKind = RSP_DATA; nData = 1'b1; nInst = ST_M; nSt = ST_I;
            end
            default: nKind = RSP_IACK;
          endcase
        end
        SNP_RFO: begin
          nSt = ST_I;
          unique case (cSt)
            ST_E, ST_M: begin
              nKind = RSP_DATA; nData = 1'b1; nInst = cSt;
            end
            ST_F: nData = 1'b1;
            default: nKind = RSP_IACK;
          endcase
        end
        default: nSt = ST_I;
      endcase
    end
  end

  always_comb begin
    str.useHead = useHead;
    str.push    = reqValid && !fifoFull && !useIn;
    str.pop     = useHead;
    str.wrState = fire && (nSt != cSt);
    str.wrVal   = nSt;
    str.setDack = fire && nData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspKind    <= RSP_IACK;
      rspHasData <= 1'b0;
      rspInstall <= ST_I;
      rspId      <= '0;
      rspLine    <= '0;
    end else begin
      rspValid <= fire;
      if (fire) begin
        rspKind    <= nKind;
        rspHasData <= nData;
        rspInstall <= nInst;
        rspId      <= cId;
        rspLine    <= cLine;
      end
    end
  end

  AST_ONE_RSP: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> rspValid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !rspValid); // R1
  AST_DATA_CARRIES: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == RSP_DATA) |-> (rspHasData && rspInstall != ST_I)); // R2
  AST_CNFL_BARE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == RSP_CNFL) |-> (!rspHasData && rspInstall == ST_I)); // R8

endmodule

// File: rtl/snoop_responder.sv
module snoop_responder
  import snoop_pkg::*;
#(
  parameter int LINES = 8,
  parameter int ID_W  = 3,
  parameter int SLOTS = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqType,
  input  logic [IDX_W-1:0] reqLine,
  input  logic [ID_W-1:0]  reqId,
  output logic             rspValid,
  output logic [1:0]       rspKind,
  output logic             rspHasData,
  output logic [2:0]       rspInstall,
  output logic [ID_W-1:0]  rspId,
  output logic [IDX_W-1:0] rspLine,
  input  logic             ownReqValid,
  input  logic [IDX_W-1:0] ownReqLine,
  input  logic             ownDoneValid,
  input  logic [IDX_W-1:0] ownDoneLine,
  input  logic [2:0]       ownDoneState,
  input  logic             evictValid,
  input  logic [IDX_W-1:0] evictLine,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbLine,
  input  logic             wbAckValid,
  input  logic [IDX_W-1:0] wbAckLine,
  input  logic             dackValid,
  input  logic [IDX_W-1:0] dackLine
);

  ctlStrobe_t       str;
  logic             fifoEmpty, fifoFull, headPend, headBlk, inPend, inBlk;
  logic [IDX_W-1:0] headLine;
  logic [ID_W-1:0]  headId;
  logic [1:0]       headType;
  lineState_t       headState, inState, rspInstallT;
  rspKind_t         rspKindT;

  assign rspKind    = rspKindT;
  assign rspInstall = rspInstallT;

  snoop_dpath #(.LINES(LINES), .ID_W(ID_W), .SLOTS(SLOTS)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str),
    .reqLine(reqLine), .reqId(reqId), .reqType(reqType),
    .ownReqValid(ownReqValid), .ownReqLine(ownReqLine),
    .ownDoneValid(ownDoneValid), .ownDoneLine(ownDoneLine), .ownDoneState(ownDoneState),
    .evictValid(evictValid), .evictLine(evictLine),
    .wbAckValid(wbAckValid), .wbAckLine(wbAckLine),
    .dackValid(dackValid), .dackLine(dackLine),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .headLine(headLine), .headId(headId), .headType(headType),
    .headState(headState), .headPend(headPend), .headBlk(headBlk),
    .inState(inState), .inPend(inPend), .inBlk(inBlk),
    .wbValid(wbValid), .wbLine(wbLine)
  );

  snoop_ctrl #(.LINES(LINES), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqLine(reqLine), .reqId(reqId), .reqType(reqType),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .headLine(headLine), .headId(headId), .headType(headType),
    .headState(headState), .headPend(headPend), .headBlk(headBlk),
    .inState(inState), .inPend(inPend), .inBlk(inBlk),
    .str(str), .reqReady(reqReady),
    .rspValid(rspValid), .rspKind(rspKindT), .rspHasData(rspHasData),
    .rspInstall(rspInstallT), .rspId(rspId), .rspLine(rspLine)
  );

endmodule

// File: tb/sim_snoop_responder.sv
module sim_snoop_responder;

  localparam int LINES = 8;
  localparam int ID_W  = 3;
  localparam int SLOTS = 4;
  localparam int IDX_W = $clog2(LINES);

  // encodings from the requirements
  localparam int SI = 0, SS = 1, SE = 2, SM = 3, SF = 4;
  localparam int K_IACK = 0, K_SACK = 1, K_DATA = 2, K_CNFL = 3;
  localparam int T_SHR = 0, T_RFO = 1, T_INV = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0; logic [1:0] reqType = 0;
  logic [IDX_W-1:0] reqLine = 0; logic [ID_W-1:0] reqId = 0;
  logic ownReqValid = 0; logic [IDX_W-1:0] ownReqLine = 0;
  logic ownDoneValid = 0; logic [IDX_W-1:0] ownDoneLine = 0; logic [2:0] ownDoneState = 0;
  logic evictValid = 0; logic [IDX_W-1:0] evictLine = 0;
  logic wbAckValid = 0; logic [IDX_W-1:0] wbAckLine = 0;
  logic dackValid = 0; logic [IDX_W-1:0] dackLine = 0;
  logic reqReady, rspValid, rspHasData, wbValid;
  logic [1:0] rspKind; logic [2:0] rspInstall;
  logic [ID_W-1:0] rspId; logic [IDX_W-1:0] rspLine, wbLine;

  always #10 clk = ~clk;

  snoop_responder #(.LINES(LINES), .ID_W(ID_W), .SLOTS(SLOTS)) u0 (.*);

  int vectors = 0, miscompares = 0;
  string curReq = "R12";
  bit checking = 0;

  // ---------------- behavioural reference model ----------------
  typedef struct { int line; int id; int typ; } held_t;
  held_t q[$];
  int mState[LINES];
  bit mPend[LINES], mDack[LINES], mWb[LINES];
  bit eRspValid, eHasData, eReady, eWbValid;
  int eKind, eInst, eId, eLine, eWbLine;

  task automatic decide(input int st, input bit pend, input int typ,
                        output int kind, output bit hd, output int inst, output int nst);
    kind = K_IACK; hd = 0; inst = SI; nst = st;
    if (pend) kind = K_CNFL;
    else if (typ == T_SHR) begin
      if (st == SS) kind = K_SACK;
      else if (st == SF || st == SE) begin kind = K_DATA; hd = 1; inst = SF; nst = SS; end
      else if (st == SM) begin kind = K_DATA; hd = 1; inst = SM; nst = SI; end
    end else if (typ == T_RFO) begin
      nst = SI;
      if (st == SE || st == SM) begin kind = K_DATA; hd = 1; inst = st; end
      else if (st == SF) hd = 1;
    end else nst = SI;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete();
      for (int i = 0; i < LINES; i++) begin mState[i] = SI; mPend[i] = 0; mDack[i] = 0; mWb[i] = 0; end
      eRspValid = 0; eReady = 1; eWbValid = 0;
    end else begin
      int preEv, kind, inst, nst;
      bit hd, useHead, useIn, acc;
      held_t c;
      preEv = mState[evictLine];
      useHead = q.size() > 0 && !(mDack[q[0].line] || mWb[q[0].line]);
      useIn = reqValid && q.size() == 0 && !(mDack[reqLine] || mWb[reqLine]);
      acc = reqValid && q.size() < SLOTS;
      eRspValid = 0; hd = 0;
      if (useHead || useIn) begin
        if (useHead) c = q[0];
        else begin c.line = reqLine; c.id = reqId; c.typ = reqType; end
        decide(mState[c.line], mPend[c.line], c.typ, kind, hd, inst, nst);
        mState[c.line] = nst;
        eRspValid = 1; eKind = kind; eHasData = hd; eInst = inst; eId = c.id; eLine = c.line;
        if (useHead) void'(q.pop_front());
      end
      if (acc && !useIn) begin
        held_t n; n.line = reqLine; n.id = reqId; n.typ = reqType; q.push_back(n);
      end
      if (dackValid) mDack[dackLine] = 0;
      if (hd) mDack[c.line] = 1;
      if (ownReqValid) mPend[ownReqLine] = 1;
      if (ownDoneValid) begin mPend[ownDoneLine] = 0; mState[ownDoneLine] = ownDoneState; end
      if (wbAckValid) mWb[wbAckLine] = 0;
      eWbValid = 0;
      if (evictValid) begin
        mState[evictLine] = SI;
        if (preEv == SM) begin mWb[evictLine] = 1; eWbValid = 1; eWbLine = evictLine; end
      end
      eReady = q.size() < SLOTS;
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic cmp(input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    vectors++;
    cmp("reqReady", int'(reqReady), int'(eReady));
    cmp("rspValid", int'(rspValid), int'(eRspValid));
    cmp("wbValid", int'(wbValid), int'(eWbValid));
    if (eRspValid && rspValid) begin
      cmp("rspKind", int'(rspKind), eKind);
      cmp("rspHasData", int'(rspHasData), int'(eHasData));
      cmp("rspInstall", int'(rspInstall), eInst);
      cmp("rspId", int'(rspId), eId);
      cmp("rspLine", int'(rspLine), eLine);
    end
    if (eWbValid && wbValid) cmp("wbLine", int'(wbLine), eWbLine);
  end

  // ---------------- stimulus tasks (called at a falling edge) ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic snoop(input int t, input int l, input int i);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqType = 2'(t); reqLine = IDX_W'(l); reqId = ID_W'(i);
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic install(input int l, input int s);
    ownDoneValid = 1; ownDoneLine = IDX_W'(l); ownDoneState = 3'(s);
    @(negedge clk);
    ownDoneValid = 0;
  endtask

  task automatic ownReq(input int l);
    ownReqValid = 1; ownReqLine = IDX_W'(l);
    @(negedge clk);
    ownReqValid = 0;
  endtask

  task automatic dack(input int l);
    dackValid = 1; dackLine = IDX_W'(l);
    @(negedge clk);
    dackValid = 0;
  endtask

  task automatic evict(input int l);
    evictValid = 1; evictLine = IDX_W'(l);
    @(negedge clk);
    evictValid = 0;
  endtask

  task automatic wbAck(input int l);
    wbAckValid = 1; wbAckLine = IDX_W'(l);
    @(negedge clk);
    wbAckValid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checking = 1;
    curReq = "R12"; idle(2);               // reset state
    curReq = "R8";
    install(0, SF); install(1, SE); install(2, SM); install(3, SS);
    install(4, SM); install(5, SF); install(6, SS);
    idle(1);

    curReq = "R2";  snoop(T_SHR, 0, 1); idle(1);   // F -> data F, local S
    curReq = "R7";  snoop(T_SHR, 0, 2);            // held behind data ack
    curReq = "R10"; snoop(T_SHR, 3, 3);            // free line queues behind
    idle(3);
    curReq = "R7";  dack(0); idle(4);              // replay: SACK line0, SACK line3

    curReq = "R4";  snoop(T_RFO, 1, 4); idle(1); dack(1);   // E -> data E
    curReq = "R3";  snoop(T_SHR, 2, 5); idle(1); dack(2);   // M -> data M
    curReq = "R5";  snoop(T_RFO, 5, 6); idle(1); dack(5);   // F -> iack + data
    snoop(T_RFO, 6, 1); idle(1);                            // S -> iack
    curReq = "R6";  snoop(T_INV, 3, 2); snoop(T_SHR, 3, 3);
    snoop(T_RFO, 1, 4); idle(2);

    curReq = "R8";  ownReq(7); snoop(T_SHR, 7, 5); idle(1);
    install(7, SM);
    curReq = "R4";  snoop(T_RFO, 7, 6); idle(1); dack(7);

    curReq = "R9";  evict(4); snoop(T_SHR, 4, 1); idle(3);
    wbAck(4); idle(3);

    curReq = "R11"; install(0, SF); snoop(T_SHR, 0, 1);
    for (int k = 0; k < SLOTS; k++) snoop(T_SHR, 0, k + 2);
    // queue holds SLOTS snoops to a held line: ready must be low
    vectors++;
    if (reqReady !== 1'b0) begin
      miscompares++;
      $display("FAIL R11 reqReady actual=%0b expected=0", reqReady);
    end
    idle(2);
    curReq = "R10"; dack(0); snoop(T_RFO, 6, 7); idle(SLOTS + 3);

    curReq = "R9";  install(2, SS); evict(2); snoop(T_SHR, 2, 3); idle(3);

    checking = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule